// File: doc/BRIEF.md
# Pixel Display Bus Slave

This block sits on an 8-bit data, 16-bit address processor bus and presents a small memory map for a toy video system. A 32 by 32 framebuffer with a 4-bit colour code per pixel occupies 1024 consecutive byte addresses. Two byte registers sit in the zero page. One gives a pseudo-random byte that moves on once for every instruction, using the processor's opcode-fetch pulse. The other holds the code of the last key pressed, loaded from a keyboard strobe.

Rows are laid out linearly: each row is 32 bytes, so every 256-byte page holds a band of eight rows. A separate scan port gives any pixel by row and column, as its colour index and a 12-bit RGB value taken from a fixed sixteen-entry palette. A video block or a bench can use it without touching the processor bus. Bus reads are registered. The read data and its drive enable appear in the cycle after the request, and the block drives the bus only for addresses it owns.

Top module: `pixel_display_slave`

## Requirements
- R1: After reset, `rd_drive` is 0, every pixel holds colour 0, the key register reads 0x00 and the random generator state is 0xACE1.
- R2: A write to address 0x0200 + 32*row + col (row and col 0..31) stores the low 4 bits of the write data as the colour of that pixel, visible on the scan port from the next cycle.
- R3: A read request to a pixel address gives, in the following cycle, `rd_drive` = 1 and `rd_data` = the stored colour in bits 3:0 with bits 7:4 zero.
- R4: The scan port gives, for colour codes 0 to 15, the RGB values 0x000, 0xFFF, 0x900, 0xAFE, 0xC4C, 0x0C5, 0x00A, 0xEE7, 0xD85, 0x640, 0xF77, 0x333, 0x777, 0xAF6, 0x08F, 0xBBB.
- R5: The 16-bit generator state s steps to {s[14:0], s[15]^s[13]^s[12]^s[10]} once for each cycle in which `bus_sync` is 1 and never becomes zero. A read of 0x00FE returns s[7:0] as held in the request cycle, before any step made in that cycle.
- R6: Writes to 0x00FE have no effect on the generator.
- R7: A key strobe loads `key_code` into the key register, a processor write to 0x00FF loads the write data, and a read of 0x00FF returns the register.
- R8: When a key strobe and a processor write to 0x00FF fall in the same cycle, the key register takes the strobe's code.
- R9: A read of any address outside 0x0200..0x05FF, 0x00FE and 0x00FF gives `rd_drive` = 0 and `rd_data` = 0x00 in the next cycle. A write there changes no pixel and no register.
- R10: In a cycle after a cycle without a read request, `rd_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data |
| bus_we | input | 1 | Write request this cycle |
| bus_re | input | 1 | Read request this cycle |
| bus_sync | input | 1 | Opcode-fetch pulse, steps the random generator |
| key_strobe | input | 1 | A key was pressed this cycle |
| key_code | input | 8 | Character code of that key |
| scan_row | input | 5 | Scan port pixel row |
| scan_col | input | 5 | Scan port pixel column |
| rd_data | output | 8 | Read data, one cycle after the request |
| rd_drive | output | 1 | Block owns the data bus this cycle |
| scan_index | output | 4 | Colour code of the scanned pixel |
| scan_rgb | output | 12 | Palette colour of the scanned pixel |

## Verification
The framebuffer is swept over all 1024 addresses with two patterns that differ in every pixel. Both patterns carry nonzero upper nibbles, so a swapped row and column, an off-by-one base or a leaked upper nibble each show up on the scan port or the bus. All sixteen colour codes go through the scan port against the palette. The generator is stepped by runs of sync pulses of several lengths, with one read taken in a sync cycle, which separates a wrong tap set from a wrong read timing. The key register is driven by strobe alone, by write alone and by both at once, and probes just outside each mapped range check that nothing answers or changes there.

// File: rtl/pdisp_pkg.sv
package pdisp_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PIX  = 2'd1,
    SEL_RNG  = 2'd2,
    SEL_KEY  = 2'd3
  } sel_e;

  // Fixed 16-entry colour table, 4 bits each of red, green, blue.
  function automatic logic [11:0] palette_rgb(input logic [3:0] idx);
    logic [11:0] rgb;
    case (idx)
      4'h0: rgb = 12'h000;
      4'h1: rgb = 12'hFFF;
      4'h2: rgb = 12'h900;
      4'h3: rgb = 12'hAFE;
      4'h4: rgb = 12'hC4C;
      4'h5: rgb = 12'h0C5;
      4'h6: rgb = 12'h00A;
      4'h7: rgb = 12'hEE7;
      4'h8: rgb = 12'hD85;
      4'h9: rgb = 12'h640;
      4'hA: rgb = 12'hF77;
      4'hB: rgb = 12'h333;
      4'hC: rgb = 12'h777;
      4'hD: rgb = 12'hAF6;
      4'hE: rgb = 12'h08F;
      default: rgb = 12'hBBB;
    endcase
    return rgb;
  endfunction

  // Maximal-length Fibonacci step, taps 16,14,13,11.
  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/pdisp_decode.sv
module pdisp_decode
  import pdisp_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          PIX_AW   = 10,
  parameter logic [15:0] PIX_BASE = 16'h0200,
  parameter logic [15:0] RNG_ADDR = 16'h00FE,
  parameter logic [15:0] KEY_ADDR = 16'h00FF
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [PIX_AW-1:0] pix_idx
);
  localparam int PIX_COUNT = 1 << PIX_AW;

  logic [ADDR_W:0] offset;
  logic            in_pix;

  always_comb begin
    offset  = {1'b0, addr} - {1'b0, PIX_BASE[ADDR_W-1:0]};
    in_pix  = !offset[ADDR_W] && (offset < (ADDR_W+1)'(PIX_COUNT));
    pix_idx = offset[PIX_AW-1:0];
    if (in_pix)                                  sel = SEL_PIX;
    else if (addr == RNG_ADDR[ADDR_W-1:0])       sel = SEL_RNG;
    else if (addr == KEY_ADDR[ADDR_W-1:0])       sel = SEL_KEY;
    else                                         sel = SEL_NONE;
  end

endmodule

// File: rtl/pdisp_fb.sv
module pdisp_fb #(
  parameter int PIX_AW  = 10,
  parameter int COLOR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [PIX_AW-1:0]  widx,
  input  logic [COLOR_W-1:0] wdata,
  input  logic [PIX_AW-1:0]  ridx,
  output logic [COLOR_W-1:0] rdata,
  input  logic [PIX_AW-1:0]  sidx,
  output logic [COLOR_W-1:0] sdata
);
  localparam int PIX_COUNT = 1 << PIX_AW;

  logic [COLOR_W-1:0] mem [PIX_COUNT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PIX_COUNT; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];
  assign sdata = mem[sidx];

  // A written pixel is what the scan port shows next cycle when it points there.
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == sidx) |=> (sdata == $past(wdata) || $past(sidx) != sidx));

endmodule

// File: rtl/pdisp_rng.sv
module pdisp_rng
  import pdisp_pkg::*;
#(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  output logic [15:0] state
);

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= lfsr_next(state);
  end

  p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state != 16'h0000);

  p_lfsr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));

  p_lfsr_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !$stable(state));

endmodule

// File: rtl/pdisp_key.sv
module pdisp_key #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [DATA_W-1:0] code,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_data,
  output logic [DATA_W-1:0] value
);

  always_ff @(posedge clk) begin
    if (!rst_n)      value <= '0;
    else if (strobe) value <= code;
    else if (cpu_we) value <= cpu_data;
  end

  p_strobe_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> value == $past(code));

  p_key_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !cpu_we) |=> $stable(value));

endmodule

// File: rtl/pixel_display_slave.sv
module pixel_display_slave
  import pdisp_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          GRID_LOG = 5,
  parameter int          COLOR_W  = 4,
  parameter int          RGB_W    = 12,
  parameter logic [15:0] PIX_BASE = 16'h0200,
  parameter logic [15:0] RNG_ADDR = 16'h00FE,
  parameter logic [15:0] KEY_ADDR = 16'h00FF,
  parameter logic [15:0] SEED     = 16'hACE1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_we,
  input  logic                bus_re,
  input  logic                bus_sync,
  input  logic                key_strobe,
  input  logic [DATA_W-1:0]   key_code,
  input  logic [GRID_LOG-1:0] scan_row,
  input  logic [GRID_LOG-1:0] scan_col,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_drive,
  output logic [COLOR_W-1:0]  scan_index,
  output logic [RGB_W-1:0]    scan_rgb
);
  localparam int PIX_AW = 2 * GRID_LOG;

  sel_e               sel;
  logic [PIX_AW-1:0]  pix_idx;
  logic [COLOR_W-1:0] fb_rdata;
  logic [15:0]        rng_state;
  logic [DATA_W-1:0]  key_val;
  logic               fb_we;
  logic               key_we;
  logic [DATA_W-1:0]  read_mux;

  pdisp_decode #(
    .ADDR_W(ADDR_W), .PIX_AW(PIX_AW), .PIX_BASE(PIX_BASE),
    .RNG_ADDR(RNG_ADDR), .KEY_ADDR(KEY_ADDR)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .pix_idx(pix_idx)
  );

  assign fb_we  = bus_we && (sel == SEL_PIX);
  assign key_we = bus_we && (sel == SEL_KEY);

  pdisp_fb #(.PIX_AW(PIX_AW), .COLOR_W(COLOR_W)) u_fb (
    .clk(clk), .rst_n(rst_n),
    .we(fb_we), .widx(pix_idx), .wdata(bus_wdata[COLOR_W-1:0]),
    .ridx(pix_idx), .rdata(fb_rdata),
    .sidx({scan_row, scan_col}), .sdata(scan_index)
  );

  pdisp_rng #(.SEED(SEED)) u_rng (
    .clk(clk), .rst_n(rst_n), .step(bus_sync), .state(rng_state)
  );

  pdisp_key #(.DATA_W(DATA_W)) u_key (
    .clk(clk), .rst_n(rst_n), .strobe(key_strobe), .code(key_code),
    .cpu_we(key_we), .cpu_data(bus_wdata), .value(key_val)
  );

  always_comb begin
    case (sel)
      SEL_PIX: read_mux = {{(DATA_W-COLOR_W){1'b0}}, fb_rdata};
      SEL_RNG: read_mux = rng_state[DATA_W-1:0];
      SEL_KEY: read_mux = key_val;
      default: read_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_drive <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_drive <= bus_re && (sel != SEL_NONE);
      rd_data  <= bus_re ? read_mux : '0;
    end
  end

  assign scan_rgb = palette_rgb(scan_index);

  p_no_drive_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && sel == SEL_NONE) |=> (!rd_drive && rd_data == '0));

  p_pix_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && sel == SEL_PIX) |=> (rd_drive && rd_data[DATA_W-1:COLOR_W] == '0));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> !rd_drive);

  p_rng_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && sel == SEL_RNG) |=> rd_data == $past(rng_state[DATA_W-1:0]));

endmodule

// File: tb/sim_pixel_display_slave.sv
module sim_pixel_display_slave;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic        bus_sync = 1'b0;
  logic        key_strobe = 1'b0;
  logic [7:0]  key_code = '0;
  logic [4:0]  scan_row = '0;
  logic [4:0]  scan_col = '0;
  logic [7:0]  rd_data;
  logic        rd_drive;
  logic [3:0]  scan_index;
  logic [11:0] scan_rgb;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model = 16'hACE1;

  always #4 clk = ~clk;

  pixel_display_slave u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_sync(bus_sync),
    .key_strobe(key_strobe), .key_code(key_code),
    .scan_row(scan_row), .scan_col(scan_col),
    .rd_data(rd_data), .rd_drive(rd_drive),
    .scan_index(scan_index), .scan_rgb(scan_rgb)
  );

  function automatic logic [11:0] exp_rgb(input logic [3:0] c);
    logic [11:0] t [16] = '{12'h000, 12'hFFF, 12'h900, 12'hAFE, 12'hC4C, 12'h0C5,
                            12'h00A, 12'hEE7, 12'hD85, 12'h640, 12'hF77, 12'h333,
                            12'h777, 12'hAF6, 12'h08F, 12'hBBB};
    return t[c];
  endfunction

  // Generator step restated as a parity over a tap mask.
  function automatic logic [15:0] model_step(input logic [15:0] s);
    return (s << 1) | 16'(^(s & 16'hB400));
  endfunction

  function automatic logic [7:0] pat(input int i, input int k);
    return 8'((i * 37 + (i >> 5) * 11 + k * 90 + 8'hA0) & 8'hFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic sync);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1; bus_sync = sync;
    @(negedge clk);
    bus_re = 1'b0; bus_sync = 1'b0;
  endtask

  task automatic sync_run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_sync = 1'b1;
      @(negedge clk);
      bus_sync = 1'b0;
      model = model_step(model);
    end
  endtask

  task automatic scan(input int i);
    scan_row = 5'(i >> 5);
    scan_col = 5'(i & 31);
    #1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 drive", 32'(rd_drive), 0);
    for (int i = 0; i < 1024; i++) begin
      scan(i);
      chk("R1 pixel", 32'(scan_index), 0);
    end
    rd(16'h00FF, 1'b0);
    chk("R1 key", 32'(rd_data), 0);
    rd(16'h00FE, 1'b0);
    chk("R1 seed", 32'(rd_data), 32'h00E1);
    @(negedge clk);
    chk("R10 idle", 32'(rd_drive), 0);

    // R2/R3/R4 two full sweeps
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 1024; i++) wr(16'h0200 + 16'(i), pat(i, k));
      for (int i = 0; i < 1024; i++) begin
        scan(i);
        chk("R2 scan index", 32'(scan_index), 32'(pat(i, k) & 8'h0F));
        chk("R4 scan rgb", 32'(scan_rgb), 32'(exp_rgb(4'(pat(i, k)))));
        rd(16'h0200 + 16'(i), 1'b0);
        chk("R3 read", {23'd0, rd_drive, rd_data}, {23'd0, 1'b1, 4'h0, 4'(pat(i, k))});
      end
    end

    // R4 every palette entry
    for (int c = 0; c < 16; c++) begin
      wr(16'h0200 + 16'(c * 33), 8'(c) | 8'hF0);
      scan(c * 33);
      chk("R4 palette", 32'(scan_rgb), 32'(exp_rgb(4'(c))));
    end

    // R5 generator runs
    sync_run(1);
    rd(16'h00FE, 1'b0);
    chk("R5 one step", 32'(rd_data), 32'(model[7:0]));
    sync_run(2);
    rd(16'h00FE, 1'b0);
    chk("R5 two steps", 32'(rd_data), 32'(model[7:0]));
    sync_run(200);
    rd(16'h00FE, 1'b0);
    chk("R5 long run", 32'(rd_data), 32'(model[7:0]));
    rd(16'h00FE, 1'b1);
    chk("R5 read in sync cycle", 32'(rd_data), 32'(model[7:0]));
    model = model_step(model);
    rd(16'h00FE, 1'b0);
    chk("R5 after sync read", 32'(rd_data), 32'(model[7:0]));

    // R6 write to generator ignored
    wr(16'h00FE, ~model[7:0]);
    rd(16'h00FE, 1'b0);
    chk("R6 write ignored", 32'(rd_data), 32'(model[7:0]));
    sync_run(1);
    rd(16'h00FE, 1'b0);
    chk("R6 sequence intact", 32'(rd_data), 32'(model[7:0]));

    // R7 key register
    wr(16'h00FF, 8'h41);
    rd(16'h00FF, 1'b0);
    chk("R7 cpu write", {23'd0, rd_drive, rd_data}, {23'd0, 1'b1, 8'h41});
    @(negedge clk);
    key_strobe = 1'b1; key_code = 8'h5A;
    @(negedge clk);
    key_strobe = 1'b0;
    rd(16'h00FF, 1'b0);
    chk("R7 strobe", 32'(rd_data), 32'h5A);

    // R8 strobe beats write
    @(negedge clk);
    bus_addr = 16'h00FF; bus_wdata = 8'h11; bus_we = 1'b1;
    key_strobe = 1'b1; key_code = 8'h77;
    @(negedge clk);
    bus_we = 1'b0; key_strobe = 1'b0;
    rd(16'h00FF, 1'b0);
    chk("R8 strobe priority", 32'(rd_data), 32'h77);

    // R9 unmapped accesses
    rd(16'h01FF, 1'b0);
    chk("R9 below pixels", {23'd0, rd_drive, rd_data}, 0);
    rd(16'h0600, 1'b0);
    chk("R9 above pixels", {23'd0, rd_drive, rd_data}, 0);
    rd(16'h00FD, 1'b0);
    chk("R9 below rng", {23'd0, rd_drive, rd_data}, 0);
    rd(16'h10FF, 1'b0);
    chk("R9 key alias", {23'd0, rd_drive, rd_data}, 0);
    scan(0);
    chk("R9 pixel 0 before", 32'(scan_index), 32'(4'(0 % 16)));
    wr(16'h01FF, 8'h0F);
    wr(16'h0600, 8'h0E);
    wr(16'h10FF, 8'h99);
    scan(0);
    chk("R9 pixel 0 kept", 32'(scan_index), 0);
    scan(1023);
    chk("R9 pixel 1023 kept", 32'(scan_index), 32'(pat(1023, 1) & 8'h0F));
    rd(16'h00FF, 1'b0);
    chk("R9 key kept", 32'(rd_data), 32'h77);
    @(negedge clk);
    chk("R10 idle after read", 32'(rd_drive), 0);

    finish_run();
  end

endmodule